// File: doc/BRIEF.md
# Decision Tree Level Stage

One pipeline stage of an axis-parallel binary decision tree classifier, responsible for a single level of the tree. Every clock cycle it may accept one tuple of unsigned 32-bit attributes from the stage above. With the tuple come a node address, a finished flag and a class label. The low bits of the node address pick one 64-bit node word from a small local table. The stage then does one of three things:

- If the tuple is already classified, it hands it on untouched.
- If the node word marks a leaf, it finishes the tuple with that leaf's class.
- Otherwise it compares one chosen attribute against the word's constant and emits the address of the left or right child in the next level.

All results leave through registers, one cycle after the input. A stage for level n holds 2^n node lines. A chain of such stages, one per level, classifies one tuple per cycle after a latency equal to the tree depth. A host fills the table through a write port that works only while the configuration-mode input is high.

Node word layout:

| Bits | Field |
|------|-------|
| [31:0] | constant |
| [35:32] | attribute index |
| [37:36] | compare code |
| [38] | leaf flag |
| [51:39] | 13-bit pointer |
| [63:52] | unused |

Top module: `dtl_stage`

## Requirements
- R1: While `rst` is high and in the cycle after it, `out_valid` and `out_done` are 0.
- R2: A tuple presented with `in_valid`=1 on a rising edge appears at the outputs one edge later: `out_valid`=1 and `out_tuple` equal to `in_tuple`. A new tuple may be presented on every consecutive cycle, and each one is handled independently.
- R3: The attribute compared is field k of `in_tuple` (bits [32k+31:32k]), where k is the word's index bits [35:32]. An index of `N_ATTR` or above compares the value 0.
- R4: The compare is unsigned, of the attribute A against the constant K (bits [31:0]). The compare codes in bits [37:36] are:
  - 00: A<K
  - 01: A<=K
  - 10: A>K
  - 11: A>=K
- R5: For a non-leaf word (bit 38 = 0) and `in_done`=0, the stage outputs `out_addr` = {pointer[51:39], result}, `out_done`=0, and `out_class` = `in_class`.
- R6: For a leaf word (bit 38 = 1) and `in_done`=0, the stage outputs `out_done`=1, `out_class` = pointer[51:39], and `out_addr`=0.
- R7: With `in_done`=1, `out_done`, `out_addr` and `out_class` equal the inputs, whatever the table holds.
- R8: The table line used is `in_addr` modulo 2^LEVEL. Higher address bits are ignored, and at level 0 the single line is always used.
- R9: A table write to line `cfg_addr` occurs only on an edge with `cfg_mode`=1 and `cfg_we`=1. Writes with either signal low leave the table unchanged.
- R10: An edge with `in_valid`=0 gives `out_valid`=0 and leaves `out_addr`, `out_class` and `out_done` at their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 1 | Configuration mode; enables table writes |
| cfg_we | input | 1 | Table write strobe |
| cfg_addr | input | max(LEVEL,1) | Table line to write |
| cfg_data | input | 64 | Node word to write |
| in_valid | input | 1 | Input slot holds a tuple |
| in_tuple | input | 32*N_ATTR | Attribute fields, field k at bits [32k+31:32k] |
| in_addr | input | 14 | Node address from the previous level |
| in_done | input | 1 | Tuple already classified |
| in_class | input | 13 | Class label from earlier levels |
| out_valid | output | 1 | Output slot holds a tuple |
| out_tuple | output | 32*N_ATTR | Forwarded attributes |
| out_addr | output | 14 | Child address for the next level |
| out_done | output | 1 | Tuple classified |
| out_class | output | 13 | Class label |

## Verification
The bench sweeps all four compare codes with the attribute below, equal to and above the constant. A design with swapped or off-by-one codes therefore shows the wrong child bit exactly at equality.

It uses an attribute index past the tuple width, with a nonzero field at the wrapped position. A design that wraps the index, instead of reading zero, picks the other child.

It sends an already-finished tuple through a leaf line, to catch a stage that reclassifies done tuples. It uses an address with high bits set, to catch wrong line decoding.

It also issues table writes with only one of the two enables high, and idle slots with a changed address. A design that gates writes loosely, or lets idle slots update the outputs, returns different values in the checks that follow.

// File: rtl/dtl_pkg.sv
package dtl_pkg;

    localparam int ATTR_W  = 32;
    localparam int AIDX_W  = 4;
    localparam int PTR_W   = 13;
    localparam int NADDR_W = PTR_W + 1;
    localparam int WORD_W  = 64;

    typedef enum logic [1:0] {
        CMP_LT = 2'b00,
        CMP_LE = 2'b01,
        CMP_GT = 2'b10,
        CMP_GE = 2'b11
    } cmp_op_e;

    typedef struct packed {
        logic [11:0]       spare;
        logic [PTR_W-1:0]  ptr;
        logic              leaf;
        cmp_op_e           op;
        logic [AIDX_W-1:0] aidx;
        logic [ATTR_W-1:0] konst;
    } node_word_t;

    function automatic logic cmp_eval(cmp_op_e op, logic [ATTR_W-1:0] a,
                                      logic [ATTR_W-1:0] k);
        logic r;
        case (op)
            CMP_LT:  r = (a <  k);
            CMP_LE:  r = (a <= k);
            CMP_GT:  r = (a >  k);
            default: r = (a >= k);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dtl_node_mem.sv
module dtl_node_mem
    import dtl_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  node_word_t       wr_word,
    input  logic [IDX_W-1:0] rd_idx,
    output node_word_t       rd_word
);

    node_word_t lines [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) lines[i] <= '0;
        end else if (wr_en && (int'(wr_idx) < DEPTH)) begin
            lines[wr_idx] <= wr_word;
        end
    end

    always_comb begin
        rd_word = '0;
        if (int'(rd_idx) < DEPTH) rd_word = lines[rd_idx];
    end

endmodule

// File: rtl/dtl_compare.sv
module dtl_compare
    import dtl_pkg::*;
#(
    parameter int N_ATTR = 8
) (
    input  logic [N_ATTR*ATTR_W-1:0] tuple,
    input  node_word_t               word,
    output logic [ATTR_W-1:0]        picked,
    output logic                     result
);

    always_comb begin
        picked = '0;
        for (int i = 0; i < N_ATTR; i++) begin
            if (word.aidx == AIDX_W'(i)) picked = tuple[i*ATTR_W +: ATTR_W];
        end
        result = cmp_eval(word.op, picked, word.konst);
    end

endmodule

// File: rtl/dtl_stage.sv
module dtl_stage
    import dtl_pkg::*;
#(
    parameter int LEVEL  = 2,
    parameter int N_ATTR = 8,
    localparam int LINES = 1 << LEVEL,
    localparam int IDX_W = (LEVEL > 0) ? LEVEL : 1,
    localparam int TUP_W = N_ATTR * ATTR_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_mode,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_addr,
    input  logic [WORD_W-1:0]  cfg_data,
    input  logic               in_valid,
    input  logic [TUP_W-1:0]   in_tuple,
    input  logic [NADDR_W-1:0] in_addr,
    input  logic               in_done,
    input  logic [PTR_W-1:0]   in_class,
    output logic               out_valid,
    output logic [TUP_W-1:0]   out_tuple,
    output logic [NADDR_W-1:0] out_addr,
    output logic               out_done,
    output logic [PTR_W-1:0]   out_class
);

    logic [IDX_W-1:0]  rd_idx;
    logic [IDX_W-1:0]  wr_idx;
    node_word_t        node;
    logic [ATTR_W-1:0] picked;
    logic              cmp_res;
    logic              wr_en;

    assign wr_en = cfg_mode & cfg_we;

    generate
        if (LEVEL > 0) begin : g_multi
            assign rd_idx = in_addr[IDX_W-1:0];
            assign wr_idx = cfg_addr;
        end else begin : g_root
            assign rd_idx = '0;
            assign wr_idx = '0;
        end
    endgenerate

    dtl_node_mem #(.DEPTH(LINES), .IDX_W(IDX_W)) i_mem (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_word (node_word_t'(cfg_data)),
        .rd_idx  (rd_idx),
        .rd_word (node)
    );

    dtl_compare #(.N_ATTR(N_ATTR)) i_cmp (
        .tuple  (in_tuple),
        .word   (node),
        .picked (picked),
        .result (cmp_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_tuple <= '0;
            out_addr  <= '0;
            out_done  <= 1'b0;
            out_class <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_tuple <= in_tuple;
                if (in_done) begin
                    out_addr  <= in_addr;
                    out_done  <= 1'b1;
                    out_class <= in_class;
                end else if (node.leaf) begin
                    out_addr  <= '0;
                    out_done  <= 1'b1;
                    out_class <= node.ptr;
                end else begin
                    out_addr  <= {node.ptr, cmp_res};
                    out_done  <= 1'b0;
                    out_class <= in_class;
                end
            end
        end
    end

endmodule

// File: rtl/dtl_stage_chk.sv
module dtl_stage_chk
    import dtl_pkg::*;
#(
    parameter int N_ATTR = 8,
    localparam int TUP_W = N_ATTR * ATTR_W
) (
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic [TUP_W-1:0]   in_tuple,
    input logic [NADDR_W-1:0] in_addr,
    input logic               in_done,
    input logic [PTR_W-1:0]   in_class,
    input logic               out_valid,
    input logic [TUP_W-1:0]   out_tuple,
    input logic [NADDR_W-1:0] out_addr,
    input logic               out_done,
    input logic [PTR_W-1:0]   out_class,
    input node_word_t         node,
    input logic               cmp_res
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_done));

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_valid && out_tuple == $past(in_tuple)));

    assert_child_addr_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_done && !node.leaf) |=>
            (!out_done && out_addr == {$past(node.ptr), $past(cmp_res)}
             && out_class == $past(in_class)));

    assert_leaf_class_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_done && node.leaf) |=>
            (out_done && out_class == $past(node.ptr) && out_addr == '0));

    assert_done_pass_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_done) |=>
            (out_done && out_addr == $past(in_addr) && out_class == $past(in_class)));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_addr) && $stable(out_class)
                       && $stable(out_done)));

endmodule

bind dtl_stage dtl_stage_chk #(.N_ATTR(N_ATTR)) i_dtl_stage_chk (.*);

// File: tb/test_dtl_stage.sv
module test_dtl_stage;
    import dtl_pkg::*;

    localparam int LEVEL  = 2;
    localparam int N_ATTR = 8;
    localparam int TUP_W  = N_ATTR * ATTR_W;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               cfg_mode = 1'b0;
    logic               cfg_we = 1'b0;
    logic [LEVEL-1:0]   cfg_addr = '0;
    logic [WORD_W-1:0]  cfg_data = '0;
    logic               in_valid = 1'b0;
    logic [TUP_W-1:0]   in_tuple = '0;
    logic [NADDR_W-1:0] in_addr = '0;
    logic               in_done = 1'b0;
    logic [PTR_W-1:0]   in_class = '0;
    logic               out_valid;
    logic [TUP_W-1:0]   out_tuple;
    logic [NADDR_W-1:0] out_addr;
    logic               out_done;
    logic [PTR_W-1:0]   out_class;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    dtl_stage #(.LEVEL(LEVEL), .N_ATTR(N_ATTR)) i_dtl_stage (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_data(cfg_data), .in_valid(in_valid),
        .in_tuple(in_tuple), .in_addr(in_addr), .in_done(in_done),
        .in_class(in_class), .out_valid(out_valid), .out_tuple(out_tuple),
        .out_addr(out_addr), .out_done(out_done), .out_class(out_class)
    );

    function automatic logic [63:0] mkword(logic [31:0] k, logic [3:0] idx,
                                           logic [1:0] op, logic leaf,
                                           logic [12:0] ptr);
        return {12'h0, ptr, leaf, op, idx, k};
    endfunction

    function automatic logic ref_cmp(logic [1:0] op, logic [31:0] a, logic [31:0] k);
        if (op == 2'b00) return a < k;
        if (op == 2'b01) return a <= k;
        if (op == 2'b10) return a > k;
        return a >= k;
    endfunction

    function automatic logic [TUP_W-1:0] mktuple(int seed);
        logic [TUP_W-1:0] t;
        for (int i = 0; i < N_ATTR; i++) t[i*ATTR_W +: ATTR_W] = 32'(seed * 1000 + i * 17 + 3);
        return t;
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic write_line(logic mode, logic we, logic [LEVEL-1:0] a, logic [63:0] w);
        @(negedge clk);
        in_valid = 1'b0;
        cfg_mode = mode; cfg_we = we; cfg_addr = a; cfg_data = w;
        @(negedge clk);
        cfg_mode = 1'b0; cfg_we = 1'b0;
    endtask

    task automatic issue(logic [TUP_W-1:0] t, logic [13:0] a, logic d, logic [12:0] c);
        @(negedge clk);
        in_valid = 1'b1; in_tuple = t; in_addr = a; in_done = d; in_class = c;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        chk("R1 out_valid", 64'(out_valid), 0);
        chk("R1 out_done", 64'(out_done), 0);
    endtask

    task automatic t_basic();
        logic [TUP_W-1:0] t = mktuple(1);
        write_line(1, 1, 2'd0, mkword(32'd100, 4'd2, 2'b00, 1'b0, 13'd5));
        t[2*32 +: 32] = 32'd50;
        issue(t, 14'd0, 1'b0, 13'd9);
        chk("R2 out_valid", 64'(out_valid), 1);
        chk("R2 out_tuple", 64'(out_tuple[2*32 +: 32]), 64'd50);
        chk("R5 addr right", 64'(out_addr), 64'd11);
        chk("R5 done low", 64'(out_done), 0);
        chk("R5 class pass", 64'(out_class), 64'd9);
        t[2*32 +: 32] = 32'd100;
        t[0 +: 32] = 32'd1;
        issue(t, 14'd0, 1'b0, 13'd4);
        chk("R2 tuple next", 64'(out_tuple[0 +: 32]), 64'd1);
        chk("R3 R5 addr left", 64'(out_addr), 64'd10);
    endtask

    task automatic t_ops();
        logic [31:0] vals [3] = '{32'd499, 32'd500, 32'd501};
        for (int op = 0; op < 4; op++) begin
            write_line(1, 1, 2'd1, mkword(32'd500, 4'd7, 2'(op), 1'b0, 13'd20));
            for (int v = 0; v < 3; v++) begin
                logic [TUP_W-1:0] t = mktuple(v + 2);
                t[7*32 +: 32] = vals[v];
                issue(t, 14'd1, 1'b0, 13'd0);
                chk("R4 compare", 64'(out_addr),
                    64'({13'd20, ref_cmp(2'(op), vals[v], 32'd500)}));
            end
        end
    endtask

    task automatic t_index_range();
        logic [TUP_W-1:0] t = mktuple(3);
        write_line(1, 1, 2'd3, mkword(32'd1, 4'd9, 2'b00, 1'b0, 13'd7));
        t[1*32 +: 32] = 32'd5;
        issue(t, 14'd3, 1'b0, 13'd0);
        chk("R3 index beyond width reads zero", 64'(out_addr), 64'd15);
    endtask

    task automatic t_leaf();
        write_line(1, 1, 2'd2, mkword(32'd0, 4'd0, 2'b11, 1'b1, 13'd1234));
        issue(mktuple(4), 14'd2, 1'b0, 13'd55);
        chk("R6 done", 64'(out_done), 1);
        chk("R6 class", 64'(out_class), 64'd1234);
        chk("R6 addr", 64'(out_addr), 0);
    endtask

    task automatic t_done_pass();
        issue(mktuple(5), 14'd2, 1'b1, 13'd77);
        chk("R7 done", 64'(out_done), 1);
        chk("R7 class", 64'(out_class), 64'd77);
        chk("R7 addr", 64'(out_addr), 64'd2);
        issue(mktuple(5), 14'd1, 1'b1, 13'd78);
        chk("R7 addr nonleaf line", 64'(out_addr), 64'd1);
    endtask

    task automatic t_alias();
        logic [TUP_W-1:0] t = mktuple(6);
        t[7*32 +: 32] = 32'd600;
        issue(t, 14'h3FF5, 1'b0, 13'd0);
        chk("R8 high bits ignored", 64'(out_addr), 64'({13'd20, 1'b1}));
    endtask

    task automatic t_write_gate();
        logic [TUP_W-1:0] t = mktuple(7);
        write_line(0, 1, 2'd0, mkword(32'd0, 4'd0, 2'b00, 1'b1, 13'd999));
        write_line(1, 0, 2'd0, mkword(32'd0, 4'd0, 2'b00, 1'b1, 13'd888));
        t[2*32 +: 32] = 32'd50;
        issue(t, 14'd0, 1'b0, 13'd0);
        chk("R9 write ignored addr", 64'(out_addr), 64'd11);
        chk("R9 write ignored done", 64'(out_done), 0);
    endtask

    task automatic t_idle();
        logic [13:0] held;
        issue(mktuple(8), 14'd2, 1'b0, 13'd3);
        held = out_addr;
        @(negedge clk);
        in_valid = 1'b0; in_addr = 14'd1; in_done = 1'b1; in_class = 13'd42;
        @(posedge clk);
        #1;
        chk("R10 valid low", 64'(out_valid), 0);
        chk("R10 addr held", 64'(out_addr), 64'(held));
        chk("R10 class held", 64'(out_class), 64'd1234);
        chk("R10 done held", 64'(out_done), 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        t_reset();
        t_basic();
        t_ops();
        t_index_range();
        t_leaf();
        t_done_pass();
        t_alias();
        t_write_gate();
        t_idle();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule